// File: doc/BRIEF.md
# Tone Decoder Event Interrupt Controller

This block gathers the level outputs of six tone-decoder event sources (voice activity, DCS turn-off tone, DCS, CTCSS, selective call, DTMF) into a status byte. It raises an interrupt request to the host whenever an enabled status bit changes, whether the bit rises or falls. A mask register selects which sources may interrupt and holds a master enable. The host acknowledges a request by reading the status register. It also sees a 20-bit notification word whose low byte mirrors the status byte.

Two flags are sticky: the DCS turn-off tone bit in the status byte and a CTCSS tail-tone flag in a separate sub-tone status register. Both stay set after the tone has gone and are cleared only by a dedicated tail-tone reset strobe. When a selective call is decoded, the block captures the channel number reported by the decoder. Every raw input passes through one register stage before edge comparison. A glitch that lasts one cycle therefore produces at most one pending request.

Top module: `tone_evt_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq` is 0, `note_word` is 0x10000, and reads of 0x22, 0x23, 0x2E and 0x30 return 0.
- R2: Register 0x22 (mask) is written with `reg_wr` and read back whole. Bits 0..5 enable the status bits of the same position in 0x23, and bit 6 is the master interrupt enable.
- R3: Register 0x23 holds the status byte: VOX 0x01, off-tone 0x02, DCS 0x04, CTCSS 0x08, selective call 0x10, DTMF 0x20, bits 7:6 zero. A raw level present at clock edge k is visible in 0x23 after edge k+1.
- R4: `irq` goes high after the edge at which an enabled status bit changes in either direction, provided mask bit 6 is set.
- R5: A change of a status bit whose mask bit is clear, or any change while mask bit 6 is clear, does not raise `irq`.
- R6: `note_word` always equals 0x100 in bits 19:8 followed by the current 0x23 byte, for example 0x10008 while only CTCSS is active.
- R7: A read of 0x23 (`reg_rd` with `reg_addr`=0x23) clears a pending request at that clock edge, so `irq` is low afterwards if no new change arrives.
- R8: If an enabled change lands at the same edge as the acknowledging read, the request stays pending and `irq` stays high.
- R9: Status bit 1 (off-tone) is set by its raw input and stays set after the input drops. It is cleared only by `tail_rst`, which has priority over setting at the same edge. Its clearing counts as a change for R4.
- R10: Bit 0 of register 0x30 is set by `ctcss_tail_in` and held until `tail_rst`. This flag never raises `irq`.
- R11: Register 0x2E bits 3:0 capture `selcall_chan` at the edge where status bit 4 rises, and hold that value at all other times.
- R12: A raw pulse of one cycle on an enabled source produces a single request, and one read of 0x23 leaves `irq` low.
- R13: Writes to 0x23, 0x2E and 0x30 have no effect on their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_raw | input | 6 | Raw decoder status levels, bit order as in 0x23 |
| ctcss_tail_in | input | 1 | CTCSS tail-tone detect level |
| selcall_chan | input | 4 | Channel number from the selective-call decoder |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; on 0x23 it acknowledges |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| tail_rst | input | 1 | Tail-tone status reset command strobe |
| irq | output | 1 | Interrupt request, high while pending |
| note_word | output | 20 | Notification frame 0x100 and status byte |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |

## Verification
Directed sequences drive a single enabled source up and then down. They tell an edge-sensitive request apart from a level-sensitive one and confirm the two-edge latency. They also drive masked sources and a cleared master enable, which separate the per-bit gating from the global gating. An acknowledge is timed to coincide with a new change, and a raw input pulses for one cycle. These cases distinguish correct pending-merge behaviour from a dropped or duplicated request. Long random runs then toggle levels, rewrite the mask and interleave reads with tail resets, and a bench model compares `irq`, `note_word` and every read each cycle. This exposes misordered sticky-clear priority and wrong channel capture.

// File: rtl/tone_evt_pkg.sv
// Shared constants for the tone decoder event interrupt controller.
// Bit positions and register addresses are fixed by the host protocol.
package tone_evt_pkg;
    localparam int EVT_N    = 6;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int CHAN_W   = 4;
    localparam int PREFIX_W = 12;

    // Status / mask bit positions
    localparam int BIT_VOX     = 0;
    localparam int BIT_OFFTONE = 1;
    localparam int BIT_DCS     = 2;
    localparam int BIT_CTCSS   = 3;
    localparam int BIT_SELCALL = 4;
    localparam int BIT_DTMF    = 5;
    localparam int BIT_MASTER  = 6;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADR_MASK = 8'h22;
    localparam logic [ADDR_W-1:0] ADR_STAT = 8'h23;
    localparam logic [ADDR_W-1:0] ADR_CHAN = 8'h2E;
    localparam logic [ADDR_W-1:0] ADR_TAIL = 8'h30;

    // Fixed upper part of the notification frame
    localparam logic [PREFIX_W-1:0] NOTE_PREFIX = 12'h100;

    // Status bits that latch until a tail-tone reset
    localparam logic [EVT_N-1:0] STICKY_BITS = 6'b000010;
endpackage

// File: rtl/tev_input_stage.sv
// Input register stage.
// Registers every raw input bit once so that later edge comparison works
// on clean, clock-aligned values. Assumes inputs are already in the clock
// domain of clk (no metastability handling needed here).
module tev_input_stage #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // One flop per input bit, cleared on reset
        always_ff @(posedge clk) begin
            if (!rst_n) q_out[i] <= 1'b0;
            else        q_out[i] <= d_in[i];
        end
    end
endmodule

// File: rtl/tev_status.sv
// Status tracker.
// Builds the next status byte from the registered raw levels. Bits named in
// STICKY hold once set until the tail-tone reset. Also keeps the CTCSS
// tail flag and captures the selective-call channel on the rising edge of
// the selective-call status bit. Assumes tail_rst is a single-cycle strobe.
module tev_status #(
    parameter int                 N       = 6,
    parameter int                 CW      = 4,
    parameter int                 SEL_BIT = 4,
    parameter logic [N-1:0]       STICKY  = 6'b000010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  sync_evt,
    input  logic          sync_tail,
    input  logic [CW-1:0] sync_chan,
    input  logic          tail_rst,
    output logic [N-1:0]  stat_q,
    output logic [N-1:0]  stat_nxt,
    output logic          tail_q,
    output logic [CW-1:0] chan_q
);
    logic sel_rise;

    for (genvar i = 0; i < N; i++) begin : g_stat
        if (STICKY[i]) begin : g_sticky
            // Latched bit: reset command wins over a set in the same cycle
            always_comb stat_nxt[i] = tail_rst ? 1'b0 : (stat_q[i] | sync_evt[i]);
        end else begin : g_level
            // Level bit follows the registered raw input
            always_comb stat_nxt[i] = sync_evt[i];
        end
    end

    // Detect the selective-call status becoming active
    always_comb sel_rise = stat_nxt[SEL_BIT] & ~stat_q[SEL_BIT];

    // Status byte register
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nxt;
    end

    // CTCSS tail-tone flag: set by detector, cleared by reset command
    always_ff @(posedge clk) begin
        if (!rst_n)        tail_q <= 1'b0;
        else if (tail_rst) tail_q <= 1'b0;
        else if (sync_tail) tail_q <= 1'b1;
    end

    // Channel capture on a fresh selective-call decode
    always_ff @(posedge clk) begin
        if (!rst_n)        chan_q <= '0;
        else if (sel_rise) chan_q <= sync_chan;
    end
endmodule

// File: rtl/tev_irq_gen.sv
// Interrupt request generator.
// Compares the next status byte with the current one, keeps the changes
// that are enabled in the mask, and sets a pending flag when the master
// enable is on. An acknowledge clears the flag unless a new enabled change
// arrives at the same edge. Assumes ack is a single-cycle strobe.
module tev_irq_gen #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat_q,
    input  logic [N-1:0] stat_nxt,
    input  logic [N:0]   mask_en,
    input  logic         ack,
    output logic         irq
);
    logic [N-1:0] chg_en;
    logic         raise;
    logic         pend_q;

    // Enabled changes in either direction
    always_comb chg_en = (stat_nxt ^ stat_q) & mask_en[N-1:0];
    // Request only when the master enable is on
    always_comb raise = mask_en[N] & (|chg_en);

    // Pending flag: a new request outranks an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (raise) pend_q <= 1'b1;
        else if (ack)   pend_q <= 1'b0;
    end

    always_comb irq = pend_q;
endmodule

// File: rtl/tev_regfile.sv
// Host register access.
// Holds the mask register, decodes the acknowledge read and multiplexes the
// read data. Status, channel and tail registers are read-only here; writes
// to them are dropped. Assumes one access per cycle.
module tev_regfile #(
    parameter int N  = 6,
    parameter int CW = 4,
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [N-1:0]  stat_q,
    input  logic [CW-1:0] chan_q,
    input  logic          tail_q,
    output logic [DW-1:0] mask_q,
    output logic          ack,
    output logic [DW-1:0] reg_rdata
);
    import tone_evt_pkg::*;

    // Mask register write
    always_ff @(posedge clk) begin
        if (!rst_n)                            mask_q <= '0;
        else if (reg_wr && reg_addr == ADR_MASK) mask_q <= reg_wdata;
    end

    // Acknowledge is a read of the status register
    always_comb ack = reg_rd && (reg_addr == ADR_STAT);

    // Read multiplexer, unknown addresses read zero
    always_comb begin
        unique case (reg_addr)
            ADR_MASK: reg_rdata = mask_q;
            ADR_STAT: reg_rdata = {{(DW-N){1'b0}}, stat_q};
            ADR_CHAN: reg_rdata = {{(DW-CW){1'b0}}, chan_q};
            ADR_TAIL: reg_rdata = {{(DW-1){1'b0}}, tail_q};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tone_evt_irq_ctrl.sv
// Tone decoder event interrupt controller, top level.
// Registers raw decoder levels, tracks the status byte and sticky flags,
// raises an edge-triggered interrupt request and exposes the notification
// frame and the host registers. Synchronous active-low reset.
module tone_evt_irq_ctrl
    import tone_evt_pkg::*;
#(
    parameter int EVT_W   = EVT_N,
    parameter int CHW     = CHAN_W,
    parameter int AW      = ADDR_W,
    parameter int DW      = DATA_W,
    parameter int PW      = PREFIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_raw,
    input  logic              ctcss_tail_in,
    input  logic [CHW-1:0]    selcall_chan,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              tail_rst,
    output logic              irq,
    output logic [PW+DW-1:0]  note_word,
    output logic [DW-1:0]     reg_rdata
);
    localparam int IN_W = EVT_W + 1 + CHW;

    logic [IN_W-1:0]  sync_bus;
    logic [EVT_W-1:0] sync_evt;
    logic             sync_tail;
    logic [CHW-1:0]   sync_chan;
    logic [EVT_W-1:0] stat_q;
    logic [EVT_W-1:0] stat_nxt;
    logic             tail_q;
    logic [CHW-1:0]   chan_q;
    logic [DW-1:0]    mask_q;
    logic             ack;

    tev_input_stage #(.W(IN_W)) u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({selcall_chan, ctcss_tail_in, evt_raw}),
        .q_out (sync_bus)
    );

    // Split the registered bus back into its fields
    always_comb begin
        sync_evt  = sync_bus[EVT_W-1:0];
        sync_tail = sync_bus[EVT_W];
        sync_chan = sync_bus[IN_W-1:EVT_W+1];
    end

    tev_status #(
        .N       (EVT_W),
        .CW      (CHW),
        .SEL_BIT (BIT_SELCALL),
        .STICKY  (STICKY_BITS)
    ) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_evt  (sync_evt),
        .sync_tail (sync_tail),
        .sync_chan (sync_chan),
        .tail_rst  (tail_rst),
        .stat_q    (stat_q),
        .stat_nxt  (stat_nxt),
        .tail_q    (tail_q),
        .chan_q    (chan_q)
    );

    tev_irq_gen #(.N(EVT_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_q   (stat_q),
        .stat_nxt (stat_nxt),
        .mask_en  (mask_q[EVT_W:0]),
        .ack      (ack),
        .irq      (irq)
    );

    tev_regfile #(.N(EVT_W), .CW(CHW), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .stat_q    (stat_q),
        .chan_q    (chan_q),
        .tail_q    (tail_q),
        .mask_q    (mask_q),
        .ack       (ack),
        .reg_rdata (reg_rdata)
    );

    // Notification frame: fixed prefix and current status byte
    always_comb note_word = {NOTE_PREFIX, {(DW-EVT_W){1'b0}}, stat_q};
endmodule

// File: rtl/tev_checker.sv
// Assertion checker for the tone decoder event interrupt controller,
// bound to the top module.
module tev_checker #(
    parameter int N  = 6,
    parameter int CW = 4,
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic [DW-1:0] mask_q,
    input logic [N-1:0]  stat_q,
    input logic [N-1:0]  stat_nxt,
    input logic          tail_q,
    input logic [CW-1:0] chan_q,
    input logic          tail_rst,
    input logic          reg_rd,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_rdata,
    input logic [DW+11:0] note_word
);
    import tone_evt_pkg::*;

    // R4: a new request needs the master enable at the previous edge
    assert_irq_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mask_q[BIT_MASTER]));

    // R5: a new request needs a status change at the same edge
    assert_irq_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$stable(stat_q));

    // R7: an acknowledge with no status change leaves irq low
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADR_STAT && stat_nxt == stat_q) |=> !irq);

    // R6: frame low byte matches the status register read
    assert_note_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_STAT) |-> (reg_rdata == note_word[DW-1:0]));

    // R9: the off-tone bit holds until the reset command
    assert_offtone_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[BIT_OFFTONE] && !tail_rst) |=> stat_q[BIT_OFFTONE]);

    // R10: the tail flag holds until the reset command
    assert_tail_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q && !tail_rst) |=> tail_q);

    // R11: channel changes only when selective-call status rises
    assert_chan_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_q) |-> $rose(stat_q[BIT_SELCALL]));
endmodule

bind tone_evt_irq_ctrl tev_checker #(.N(EVT_W), .CW(CHW), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .stat_nxt  (stat_nxt),
    .tail_q    (tail_q),
    .chan_q    (chan_q),
    .tail_rst  (tail_rst),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .note_word (note_word)
);

// File: tb/tb_tone_evt_irq_ctrl.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared each cycle against a model built from the requirements.
module tb_tone_evt_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_raw = '0;
    logic        ctcss_tail_in = 1'b0;
    logic [3:0]  selcall_chan = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        tail_rst = 1'b0;
    logic        irq;
    logic [19:0] note_word;
    logic [7:0]  reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    logic [5:0] m_sync, m_stat;
    logic       m_stail, m_tailf, m_pend;
    logic [3:0] m_schan, m_chan;
    logic [7:0] m_mask;

    always #10 clk = ~clk;

    tone_evt_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_raw(evt_raw), .ctcss_tail_in(ctcss_tail_in),
        .selcall_chan(selcall_chan), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tail_rst(tail_rst),
        .irq(irq), .note_word(note_word), .reg_rdata(reg_rdata)
    );

    task automatic chk(input logic [19:0] act, input logic [19:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h22:   return m_mask;
            8'h23:   return {2'b00, m_stat};
            8'h2E:   return {4'h0, m_chan};
            8'h30:   return {7'h0, m_tailf};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        case (a)
            8'h22:   return "R2 mask read";
            8'h23:   return "R3 status read";
            8'h2E:   return "R11 channel read";
            default: return "R10 tail read";
        endcase
    endfunction

    task automatic model_edge();
        logic [5:0] ns;
        logic [5:0] chg;
        if (!rst_n) begin
            m_sync = '0; m_stail = 0; m_schan = '0; m_stat = '0;
            m_tailf = 0; m_pend = 0; m_chan = '0; m_mask = '0;
            return;
        end
        ns = m_sync;
        ns[1] = tail_rst ? 1'b0 : (m_stat[1] | m_sync[1]);
        chg = (ns ^ m_stat) & m_mask[5:0];
        if (m_mask[6] && (|chg)) m_pend = 1'b1;
        else if (reg_rd && reg_addr == 8'h23) m_pend = 1'b0;
        if (!m_stat[4] && ns[4]) m_chan = m_schan;
        m_tailf = tail_rst ? 1'b0 : (m_tailf | m_stail);
        if (reg_wr && reg_addr == 8'h22) m_mask = reg_wdata;
        m_stat  = ns;
        m_sync  = evt_raw;
        m_stail = ctcss_tail_in;
        m_schan = selcall_chan;
    endtask

    // One cycle: inputs set at a falling edge, checks at the next one
    task automatic cyc();
        #1;
        if (reg_rd && rst_n) chk({12'h0, reg_rdata}, {12'h0, exp_rd(reg_addr)}, rd_tag(reg_addr));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (rst_n) begin
            chk({19'h0, irq}, {19'h0, m_pend}, "R4 irq");
            chk(note_word, {12'h100, 2'b00, m_stat}, "R6 frame");
        end
        reg_wr = 0; reg_rd = 0; tail_rst = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        cyc();
    endtask

    task automatic rd_reg(input logic [7:0] a);
        reg_rd = 1; reg_addr = a;
        cyc();
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
        reg_rd = 1; reg_addr = a;
        #1;
        chk({12'h0, reg_rdata}, {12'h0, e}, tag);
        #0;
        cyc();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1: reset state
        idle(3);
        chk({19'h0, irq}, 20'h0, "R1 irq at reset");
        chk(note_word, 20'h10000, "R1 frame at reset");
        rst_n = 1;
        rd_expect(8'h22, 8'h00, "R1 mask after reset");
        rd_expect(8'h23, 8'h00, "R1 status after reset");
        rd_expect(8'h2E, 8'h00, "R1 channel after reset");
        rd_expect(8'h30, 8'h00, "R1 tail after reset");

        // R2: mask write/readback (master + CTCSS)
        wr_reg(8'h22, 8'h48);
        rd_expect(8'h22, 8'h48, "R2 mask readback");

        // R3/R4/R6: CTCSS rising, two-edge latency
        evt_raw[3] = 1;
        idle(1);
        chk({19'h0, irq}, 20'h0, "R3 not yet visible");
        idle(1);
        chk({19'h0, irq}, 20'h1, "R4 irq on rise");
        chk(note_word, 20'h10008, "R6 CTCSS frame");
        // R7: acknowledge
        rd_expect(8'h23, 8'h08, "R3 CTCSS status");
        chk({19'h0, irq}, 20'h0, "R7 irq cleared by read");

        // R4: falling change also interrupts
        evt_raw[3] = 0;
        idle(2);
        chk({19'h0, irq}, 20'h1, "R4 irq on fall");
        chk(note_word, 20'h10000, "R6 frame after fall");
        rd_reg(8'h23);

        // R5: masked source
        evt_raw[0] = 1;
        idle(3);
        chk({19'h0, irq}, 20'h0, "R5 masked VOX");
        chk(note_word, 20'h10001, "R6 VOX frame");
        evt_raw[0] = 0;
        idle(3);

        // R5: master enable clear
        wr_reg(8'h22, 8'h08);
        evt_raw[3] = 1;
        idle(3);
        chk({19'h0, irq}, 20'h0, "R5 master off");
        evt_raw[3] = 0;
        idle(3);

        // R8: change coincides with acknowledge
        wr_reg(8'h22, 8'h48);
        evt_raw[3] = 1;
        idle(2);
        chk({19'h0, irq}, 20'h1, "R8 first request");
        evt_raw[3] = 0;
        idle(1);
        rd_reg(8'h23);
        chk({19'h0, irq}, 20'h1, "R8 request kept");
        rd_reg(8'h23);
        chk({19'h0, irq}, 20'h0, "R8 second ack clears");

        // R9: off-tone latch and reset command
        wr_reg(8'h22, 8'h42);
        evt_raw[1] = 1;
        idle(2);
        chk({19'h0, irq}, 20'h1, "R9 off-tone request");
        rd_reg(8'h23);
        evt_raw[1] = 0;
        idle(3);
        chk(note_word, 20'h10002, "R9 off-tone held");
        chk({19'h0, irq}, 20'h0, "R9 no request while held");
        tail_rst = 1;
        cyc();
        chk(note_word, 20'h10000, "R9 cleared by command");
        chk({19'h0, irq}, 20'h1, "R9 clear is a change");
        rd_reg(8'h23);

        // R10: CTCSS tail flag
        ctcss_tail_in = 1;
        idle(1);
        ctcss_tail_in = 0;
        idle(3);
        rd_expect(8'h30, 8'h01, "R10 tail flag held");
        chk({19'h0, irq}, 20'h0, "R10 no request from tail");
        tail_rst = 1;
        cyc();
        rd_expect(8'h30, 8'h00, "R10 tail flag cleared");

        // R11: channel capture
        wr_reg(8'h22, 8'h50);
        selcall_chan = 4'd9;
        evt_raw[4] = 1;
        idle(2);
        rd_expect(8'h2E, 8'h09, "R11 channel captured");
        selcall_chan = 4'd3;
        idle(3);
        rd_expect(8'h2E, 8'h09, "R11 channel held");
        evt_raw[4] = 0;
        idle(2);
        rd_reg(8'h23);

        // R12: single-cycle glitch
        wr_reg(8'h22, 8'h41);
        evt_raw[0] = 1;
        cyc();
        evt_raw[0] = 0;
        idle(3);
        chk({19'h0, irq}, 20'h1, "R12 glitch requests");
        rd_reg(8'h23);
        idle(2);
        chk({19'h0, irq}, 20'h0, "R12 single request");

        // R13: writes to read-only registers
        wr_reg(8'h23, 8'hFF);
        wr_reg(8'h2E, 8'hFF);
        wr_reg(8'h30, 8'hFF);
        rd_expect(8'h23, 8'h00, "R13 status unchanged");
        rd_expect(8'h2E, 8'h09, "R13 channel unchanged");
        rd_expect(8'h30, 8'h00, "R13 tail unchanged");

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int op;
            for (int b = 0; b < 6; b++)
                if ($urandom_range(0, 9) == 0) evt_raw[b] = ~evt_raw[b];
            ctcss_tail_in = ($urandom_range(0, 19) == 0);
            selcall_chan  = 4'($urandom_range(0, 15));
            op = $urandom_range(0, 19);
            if (op == 0) begin
                reg_wr = 1; reg_addr = 8'h22; reg_wdata = 8'($urandom_range(0, 255));
            end else if (op < 6) begin
                reg_rd = 1;
                case ($urandom_range(0, 4))
                    0: reg_addr = 8'h22;
                    1: reg_addr = 8'h2E;
                    2: reg_addr = 8'h30;
                    default: reg_addr = 8'h23;
                endcase
            end else if (op == 6) begin
                tail_rst = 1;
            end
            cyc();
        end

        done = 1'b1;
        finish_run();
    end
endmodule